// File: doc/BRIEF.md
# Periodic Interval Timer with Deferred Reload

This block is a down-counting interval timer that runs from a low-frequency reference of 32768 Hz. The reference arrives as a one-cycle enable pulse in the system clock domain, so every register shares one clock. A fixed divide-by-four prescaler turns those pulses into a counting tick of 8192 Hz, which is about 122.07 microseconds per tick. Each tick lowers a live counter by one.

Software writes a reload value into a holding register through a small register bus. The write does not disturb the running count. The held value reaches the live counter only when the counter passes below zero. At that moment a sticky expiry flag is set. Software either polls the flag or enables it as an interrupt request. Software can read the live counter back and watch individual ticks go by.

A two-state machine governs counting. In `MODE_HALT` the prescaler and counter hold their values. In `MODE_RUN` they advance on reference pulses. A control write with the run bit set takes the transition HALT→RUN. A control write with the run bit clear takes RUN→HALT. Every other cycle keeps the current state.

Top module: `interval_timer`

## Requirements
- R1: After reset the control register (address 0) reads 0, the reload register (address 1) and live counter (address 2) read all ones, and `irq` is low.
- R2: While running, exactly one counting tick occurs per DIV (default 4) reference pulses. The live counter does not change between ticks.
- R3: On a tick with a nonzero live value, the counter decreases by exactly one.
- R4: Writing the reload register (address 1) leaves the live counter unchanged.
- R5: A tick that finds the live counter at zero loads the most recently written reload value and sets the expiry flag (control bit 2).
- R6: The expiry flag is sticky. Writing control with bit 2 = 1 clears it. Writing control with bit 2 = 0 leaves it unchanged.
- R7: An underflow in the same cycle as a flag-clearing write leaves the flag set.
- R8: `irq` is high exactly when the expiry flag and the interrupt enable (control bit 1) are both set.
- R9: With the run bit (control bit 0) clear, both the prescaler phase and the live counter hold their values.
- R10: Address 2 is read-only: writes to it are ignored. Address 3 reads 0. Control reads as {flag, int enable, run} in bits 2..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lf_pulse | input | 1 | One-cycle pulse per 32768 Hz reference edge |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A prescaler phase that is off by one shifts every later tick. It shows at the live-counter port one reference pulse early or late, at the first check after a multiple of four pulses. A wrong reload path shows in the cycle after underflow, when address 2 holds a value other than the last reload written. A faulty flag priority or mask shows on `irq` in the cycle after the colliding write. The bench uses a narrow counter so that underflow from the all-ones reset value is reached within a short run.

// File: rtl/timer_pkg.sv
package timer_pkg;
    typedef enum logic {
        MODE_HALT = 1'b0,
        MODE_RUN  = 1'b1
    } mode_e;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_RELOAD = 2'd1;
    localparam logic [1:0] ADDR_LIVE   = 2'd2;

    localparam int BIT_RUN  = 0;
    localparam int BIT_IEN  = 1;
    localparam int BIT_FLAG = 2;
endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic lf_pulse,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    assign tick = run && lf_pulse && (phase_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (run && lf_pulse) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + PW'(1);
        end
    end

    // R9: the phase holds while stopped
    assert_phase_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(phase_q));
endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] hold,
    output logic [W-1:0] live,
    output logic         underflow
);
    logic [W-1:0] live_q;

    assign live      = live_q;
    assign underflow = tick && (live_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '1;
        end else if (tick) begin
            live_q <= (live_q == '0) ? hold : live_q - W'(1);
        end
    end

    assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && live_q != '0) |=> live_q == $past(live_q) - W'(1));

    assert_reload_on_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> live_q == $past(hold));

    assert_stable_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(live_q));
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int CNT_W = 16,
    parameter int DIV   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lf_pulse,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);
    import timer_pkg::*;

    mode_e            state_q, state_d;
    logic             ien_q, flag_q;
    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] live;
    logic             tick, underflow;
    logic             wr_ctrl, wr_reload;

    assign wr_ctrl   = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_reload = bus_wr && (bus_addr == ADDR_RELOAD);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_HALT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_HALT: if (wr_ctrl &&  bus_wdata[BIT_RUN]) state_d = MODE_RUN;
            MODE_RUN:  if (wr_ctrl && !bus_wdata[BIT_RUN]) state_d = MODE_HALT;
            default:   state_d = MODE_HALT;
        endcase
    end

    // control and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q  <= 1'b0;
            flag_q <= 1'b0;
            hold_q <= '1;
        end else begin
            if (wr_ctrl)   ien_q  <= bus_wdata[BIT_IEN];
            if (wr_reload) hold_q <= bus_wdata;
            if (underflow)
                flag_q <= 1'b1;
            else if (wr_ctrl && bus_wdata[BIT_FLAG])
                flag_q <= 1'b0;
        end
    end

    ptmr_prescale #(.DIV(DIV)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q == MODE_RUN),
        .lf_pulse (lf_pulse),
        .tick     (tick)
    );

    ptmr_count #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .hold      (hold_q),
        .live      (live),
        .underflow (underflow)
    );

    // outputs
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[BIT_RUN]  = (state_q == MODE_RUN);
                bus_rdata[BIT_IEN]  = ien_q;
                bus_rdata[BIT_FLAG] = flag_q;
            end
            ADDR_RELOAD: bus_rdata = hold_q;
            ADDR_LIVE:   bus_rdata = live;
            default:     bus_rdata = '0;
        endcase
        irq = flag_q && ien_q;
    end

    assert_underflow_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> flag_q);

    assert_halt_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_HALT) |=> $stable(live));

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !wr_ctrl) |=> flag_q);

    assert_reload_write_no_touch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_reload && !tick) |=> $stable(live));
endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lf_pulse = 1'b0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    interval_timer #(.CNT_W(W), .DIV(4)) i_interval_timer (
        .clk(clk), .rst_n(rst_n), .lf_pulse(lf_pulse), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // table: reload written, reference pulses, expected live, expected flag
    localparam logic [W-1:0] T_RELOAD [4] = '{8'd2, 8'd2, 8'd1, 8'd7};
    localparam int           T_PULSES [4] = '{8, 12, 4, 8};
    localparam logic [W-1:0] T_LIVE   [4] = '{8'd3, 8'd0, 8'd1, 8'd7};
    localparam logic         T_FLAG   [4] = '{1'b1, 1'b1, 1'b1, 1'b1};

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
        @(negedge clk);
        bus_addr = a;
        #0.5 v = bus_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lf_pulse = 1'b1;
        end
        @(negedge clk);
        lf_pulse = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values; R10 address 3 reads 0
        rd(2'd0, v); check("R1 ctrl", v, 8'h00);
        rd(2'd1, v); check("R1 reload", v, 8'hFF);
        rd(2'd2, v); check("R1 live", v, 8'hFF);
        check("R1 irq", {7'd0, irq}, 8'd0);
        rd(2'd3, v); check("R10 addr3", v, 8'h00);

        // R2 / R3: one tick per four pulses
        wr(2'd0, 8'h01);
        pulses(3);
        rd(2'd2, v); check("R2 no change mid-prescale", v, 8'hFF);
        pulses(1);
        rd(2'd2, v); check("R3 one decrement", v, 8'hFE);

        // R9: halted, pulses have no effect on counter or phase
        wr(2'd0, 8'h00);
        pulses(8);
        rd(2'd2, v); check("R9 frozen", v, 8'hFE);
        wr(2'd0, 8'h01);
        pulses(3);
        rd(2'd2, v); check("R9 phase held", v, 8'hFE);
        pulses(1);
        rd(2'd2, v); check("R9 resumes", v, 8'hFD);

        // R4: reload write leaves live alone
        wr(2'd1, 8'd5);
        rd(2'd2, v); check("R4 deferred", v, 8'hFD);

        // run down to zero, then underflow (R5), polled (R8 irq stays low)
        pulses(253 * 4);
        rd(2'd2, v); check("R5 at zero", v, 8'h00);
        rd(2'd0, v); check("R5 flag clear before", v, 8'h01);
        pulses(4);
        rd(2'd2, v); check("R5 reloaded", v, 8'd5);
        rd(2'd0, v); check("R5 flag set", v, 8'h05);
        check("R8 irq masked", {7'd0, irq}, 8'd0);

        // table walk: latest reload wins, flag sticky
        for (int k = 0; k < 4; k++) begin
            wr(2'd1, T_RELOAD[k]);
            pulses(T_PULSES[k]);
            rd(2'd2, v); check("R5 table live", v, T_LIVE[k]);
            rd(2'd0, v); check("R6 table flag", {7'd0, v[2]}, {7'd0, T_FLAG[k]});
        end

        // R6 write 0 keeps flag; R8 irq rises with enable
        wr(2'd0, 8'h03);
        rd(2'd0, v); check("R6 write zero keeps flag", v, 8'h07);
        check("R8 irq on", {7'd0, irq}, 8'd1);
        wr(2'd0, 8'h07);
        rd(2'd0, v); check("R6 cleared", v, 8'h03);
        check("R8 irq off", {7'd0, irq}, 8'd0);

        // R10: live register is read-only
        wr(2'd2, 8'h12);
        rd(2'd2, v); check("R10 live read-only", v, 8'd7);

        // R7: underflow collides with clear
        pulses(28);
        rd(2'd2, v); check("R7 at zero", v, 8'h00);
        pulses(3);
        @(negedge clk);
        lf_pulse = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h07;
        @(negedge clk);
        lf_pulse = 1'b0; bus_wr = 1'b0;
        rd(2'd0, v); check("R7 flag wins", v, 8'h07);
        check("R7 irq", {7'd0, irq}, 8'd1);
        rd(2'd2, v); check("R7 reloaded", v, 8'd7);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule